// File: doc/BRIEF.md
# Pulse-Swallow Dual-Modulus Feedback Divider

This block divides a fast input clock by a programmable integer N = B·P + A, where P is the base ratio of a prescaler that can also divide by P+1. A swallow counter (A) and a main counter (B) are both clocked by the prescaler's output ticks. While A has ticks left to count, the prescaler divides by P+1. After A runs out, it divides by P for the rest of the B count. When B runs out, the period ends: one output pulse is issued and both counters reload from their presets in the same cycle. The result is integer-step resolution of N, while the programmable counters only ever see the slow prescaler rate.

It sits in the feedback path of a frequency synthesizer. The one-cycle output pulse goes to the phase comparison logic. The modulus-control output shows which ratio the prescaler is currently using. Presets and the ratio select are sampled only when a period starts, so a change of settings always gives whole periods. Settings that cannot produce a correct count are caught when they are sampled. The block then parks in a fault state with its outputs quiet, and it leaves that state as soon as valid settings appear.

The control is a four-state machine:
- ST_PRIME is the state after reset.
- ST_SWALLOW is active while the prescaler divides by P+1.
- ST_PLAIN is active while the prescaler divides by P.
- ST_FAULT holds while the settings are invalid.

Transitions:
- PRIME → SWALLOW, PLAIN or FAULT on the first clock after reset. The target depends on the presets: FAULT if they are invalid, PLAIN if A is zero, SWALLOW otherwise.
- SWALLOW → PLAIN when the last swallow tick completes.
- SWALLOW/PLAIN → reload target when B runs out. The target is chosen by the same rule as from PRIME.
- FAULT → reload target on every clock. The block stays in FAULT while the presets remain invalid.

Top module: `swallow_divider`

## Requirements
- R1: With `ratio_sel`=0 (P=32) or `ratio_sel`=1 (P=64), consecutive `div_out` pulses are exactly B·P + A input cycles apart.
- R2: `div_out` is high for exactly one input cycle per period, and that cycle is the last cycle of the period.
- R3: `modulus_hi` is high for exactly A·(P+1) cycles of each period, which are the first cycles of that period, and low for the remaining (B−A)·P cycles.
- R4: With A = B, `modulus_hi` stays high for the whole period and the period is B·(P+1).
- R5: With A = 0, `modulus_hi` never rises and the period is B·P.
- R6: `swallow_cnt`, `main_cnt` and `ratio_sel` are sampled only when a period starts. A change made mid-period leaves that period's length unchanged and takes effect in the next period.
- R7: `cfg_fault` goes high at the sampling point when B = 0, when B < A, or when A ≥ P for the selected ratio. An A value of P or more is accepted when the other ratio makes it valid.
- R8: While `cfg_fault` is high, `div_out` and `modulus_hi` are low. Once valid settings are present, `cfg_fault` clears at the next clock and the first pulse arrives N clocks after that clock.
- R9: While `rst_n` is low, all outputs are low. After release, the first `div_out` pulse is high immediately after the N-th rising clock edge.
- R10: The largest settings, A = P−1 and B at its counter maximum, divide correctly.
- R11: With B = P−1, A steps from 0 to P−1 give periods P²−P to P²−1 with no gaps. The smallest of these is 992 for P=32.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast input clock to be divided |
| rst_n | input | 1 | Asynchronous active-low reset |
| ratio_sel | input | 1 | Prescaler base ratio: 0 selects P_LO (32), 1 selects P_HI (64) |
| swallow_cnt | input | A_W | Preset A, the number of P+1 prescaler cycles per period |
| main_cnt | input | B_W | Preset B, the total number of prescaler cycles per period |
| div_out | output | 1 | One-cycle pulse in the last input cycle of each period |
| modulus_hi | output | 1 | High while the prescaler divides by P+1 |
| cfg_fault | output | 1 | High while the sampled settings are invalid |

## Verification
The bench builds the block with A_W = 6 and B_W = 8 and keeps the default ratios 32 and 64. The 6-bit A field can hold values of P or more for P=32, so the A ≥ P check is reachable. The same value is valid under P=64, so the bench can show the check follows the selected ratio. With an 8-bit B, the largest count (255·64 + 63 = 16383) runs in a few tens of thousands of cycles. This puts the maximum-setting case and the P²−P contiguity boundary within reach next to the ordinary period and modulus-control measurements.

// File: rtl/swd_pkg.sv
`timescale 1ns/1ps
package swd_pkg;

    typedef enum logic [1:0] {
        ST_PRIME   = 2'd0,
        ST_SWALLOW = 2'd1,
        ST_PLAIN   = 2'd2,
        ST_FAULT   = 2'd3
    } swd_state_e;

    function automatic int unsigned max3(input int unsigned x, input int unsigned y,
                                         input int unsigned z);
        int unsigned m;
        m = (x > y) ? x : y;
        return (m > z) ? m : z;
    endfunction

endpackage

// File: rtl/swd_prescaler.sv
`timescale 1ns/1ps
module swd_prescaler #(
    parameter int PC_W = 7
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            run,
    input  logic            plus_one,
    input  logic [PC_W-1:0] base_ratio,
    output logic            tick
);
    logic [PC_W-1:0] count_q;
    logic [PC_W-1:0] last_val;

    // terminal count is P for divide-by-(P+1), P-1 for divide-by-P
    always_comb begin
        last_val = plus_one ? base_ratio : (base_ratio - 1'b1);
        tick     = run && (count_q == last_val);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count_q <= '0;
        end else if (!run || tick) begin
            count_q <= '0;
        end else begin
            count_q <= count_q + 1'b1;
        end
    end
endmodule

// File: rtl/swd_ab_counters.sv
`timescale 1ns/1ps
module swd_ab_counters #(
    parameter int A_W = 6,
    parameter int B_W = 13
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           load,
    input  logic           step,
    input  logic [A_W-1:0] a_preset,
    input  logic [B_W-1:0] b_preset,
    output logic           a_last,
    output logic           b_last
);
    logic [A_W-1:0] a_q;
    logic [B_W-1:0] b_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            a_q <= '0;
            b_q <= '0;
        end else if (load) begin
            a_q <= a_preset;
            b_q <= b_preset;
        end else if (step) begin
            b_q <= b_q - 1'b1;
            if (a_q != '0) begin
                a_q <= a_q - 1'b1;
            end
        end
    end

    always_comb begin
        a_last = (a_q == A_W'(1));
        b_last = (b_q == B_W'(1));
    end
endmodule

// File: rtl/swd_cfg_check.sv
`timescale 1ns/1ps
module swd_cfg_check #(
    parameter int A_W  = 6,
    parameter int B_W  = 13,
    parameter int PC_W = 7
) (
    input  logic [A_W-1:0]  a_val,
    input  logic [B_W-1:0]  b_val,
    input  logic [PC_W-1:0] p_val,
    output logic            cfg_ok,
    output logic            a_is_zero
);
    localparam int CW = swd_pkg::max3(A_W, B_W, PC_W);

    logic [CW-1:0] a_ext;
    logic [CW-1:0] b_ext;
    logic [CW-1:0] p_ext;

    always_comb begin
        a_ext     = CW'(a_val);
        b_ext     = CW'(b_val);
        p_ext     = CW'(p_val);
        cfg_ok    = (b_ext != '0) && (a_ext <= b_ext) && (a_ext < p_ext);
        a_is_zero = (a_val == '0);
    end
endmodule

// File: rtl/swallow_divider.sv
`timescale 1ns/1ps
module swallow_divider #(
    parameter int P_LO = 32,
    parameter int P_HI = 64,
    parameter int A_W  = 6,
    parameter int B_W  = 13
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           ratio_sel,
    input  logic [A_W-1:0] swallow_cnt,
    input  logic [B_W-1:0] main_cnt,
    output logic           div_out,
    output logic           modulus_hi,
    output logic           cfg_fault
);
    import swd_pkg::*;

    localparam int PC_W = $clog2(P_HI + 1);
    localparam logic [PC_W-1:0] P_LO_V = PC_W'(P_LO);
    localparam logic [PC_W-1:0] P_HI_V = PC_W'(P_HI);

    swd_state_e      state;
    swd_state_e      state_nx;
    logic            ratio_q;
    logic [PC_W-1:0] p_run;
    logic [PC_W-1:0] p_new;
    logic            running;
    logic            tick;
    logic            a_last;
    logic            b_last;
    logic            terminal;
    logic            load;
    logic            cfg_ok;
    logic            a_zero;
    swd_state_e      restart_st;

    always_comb begin
        p_run    = ratio_q   ? P_HI_V : P_LO_V;
        p_new    = ratio_sel ? P_HI_V : P_LO_V;
        running  = (state == ST_SWALLOW) || (state == ST_PLAIN);
        terminal = running && tick && b_last;
        load     = (state == ST_PRIME) || (state == ST_FAULT) || terminal;
    end

    swd_prescaler #(.PC_W(PC_W)) u_psc (
        .clk        (clk),
        .rst_n      (rst_n),
        .run        (running),
        .plus_one   (state == ST_SWALLOW),
        .base_ratio (p_run),
        .tick       (tick)
    );

    swd_ab_counters #(.A_W(A_W), .B_W(B_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .step     (tick && !load),
        .a_preset (swallow_cnt),
        .b_preset (main_cnt),
        .a_last   (a_last),
        .b_last   (b_last)
    );

    swd_cfg_check #(.A_W(A_W), .B_W(B_W), .PC_W(PC_W)) u_chk_cfg (
        .a_val     (swallow_cnt),
        .b_val     (main_cnt),
        .p_val     (p_new),
        .cfg_ok    (cfg_ok),
        .a_is_zero (a_zero)
    );

    // state entered whenever presets are sampled
    always_comb begin
        if (!cfg_ok) begin
            restart_st = ST_FAULT;
        end else if (a_zero) begin
            restart_st = ST_PLAIN;
        end else begin
            restart_st = ST_SWALLOW;
        end
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_PRIME:   state_nx = restart_st;
            ST_FAULT:   state_nx = restart_st;
            ST_SWALLOW: begin
                if (tick && b_last) begin
                    state_nx = restart_st;
                end else if (tick && a_last) begin
                    state_nx = ST_PLAIN;
                end
            end
            ST_PLAIN: begin
                if (tick && b_last) begin
                    state_nx = restart_st;
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= ST_PRIME;
            ratio_q <= 1'b0;
        end else begin
            state <= state_nx;
            if (load) begin
                ratio_q <= ratio_sel;
            end
        end
    end

    always_comb begin
        div_out    = terminal;
        modulus_hi = (state == ST_SWALLOW);
        cfg_fault  = (state == ST_FAULT);
    end
endmodule

// File: rtl/swd_chk.sv
`timescale 1ns/1ps
module swd_chk #(
    parameter int P_LO = 32
) (
    input logic               clk,
    input logic               rst_n,
    input logic               div_out,
    input logic               modulus_hi,
    input logic               cfg_fault,
    input swd_pkg::swd_state_e state
);
    import swd_pkg::*;

    logic [31:0] gap_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gap_q <= '0;
        end else if (div_out) begin
            gap_q <= '0;
        end else if (gap_q != 32'hFFFF_FFFF) begin
            gap_q <= gap_q + 1'b1;
        end
    end

    // R8
    fault_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_fault |-> (!div_out && !modulus_hi));

    // R2
    pulse_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        div_out |=> !div_out);

    // R1
    min_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        div_out |-> (gap_q >= 32'(P_LO - 1)));

    // R6
    fault_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cfg_fault) |-> ($past(div_out) || ($past(state) == ST_PRIME)));

    // R3
    mod_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(modulus_hi) |-> ($past(div_out) || ($past(state) == ST_PRIME)
                               || ($past(state) == ST_FAULT)));
endmodule

bind swallow_divider swd_chk #(.P_LO(P_LO)) u_swd_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .div_out    (div_out),
    .modulus_hi (modulus_hi),
    .cfg_fault  (cfg_fault),
    .state      (state)
);

// File: tb/swallow_divider_test.sv
`timescale 1ns/1ps
module swallow_divider_test;
    localparam int A_W = 6;
    localparam int B_W = 8;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           ratio_sel = 1'b0;
    logic [A_W-1:0] swallow_cnt = '0;
    logic [B_W-1:0] main_cnt = 8'd1;
    logic           div_out;
    logic           modulus_hi;
    logic           cfg_fault;

    int n_checks = 0;
    int n_fails  = 0;
    int cycles   = 0;

    swallow_divider #(.P_LO(32), .P_HI(64), .A_W(A_W), .B_W(B_W)) uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .ratio_sel   (ratio_sel),
        .swallow_cnt (swallow_cnt),
        .main_cnt    (main_cnt),
        .div_out     (div_out),
        .modulus_hi  (modulus_hi),
        .cfg_fault   (cfg_fault)
    );

    always #2 clk = ~clk;

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles == 190000) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic setup(input int a, input int b, input bit m);
        swallow_cnt = A_W'(a);
        main_cnt    = B_W'(b);
        ratio_sel   = m;
    endtask

    // counts negedges until div_out is seen high; returns length and modulus_hi cycles
    task automatic measure(output int n, output int mh);
        n  = 0;
        mh = 0;
        for (int i = 0; i < 40000; i++) begin
            @(negedge clk);
            n++;
            if (modulus_hi) mh++;
            if (div_out) break;
        end
    endtask

    task automatic run_case(input int a, input int b, input bit m, input string tag);
        int n, mh, p;
        p = m ? 64 : 32;
        setup(a, b, m);
        measure(n, mh);
        measure(n, mh);
        check(n == b * p + a, {tag, " period"}, n, b * p + a);
        check(mh == a * (p + 1), {tag, " modulus_hi cycles"}, mh, a * (p + 1));
    endtask

    task automatic t_reset();
        int n, mh;
        setup(5, 10, 1'b0);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check(!div_out && !modulus_hi && !cfg_fault, "R9 outputs in reset",
              {div_out, modulus_hi, cfg_fault}, 0);
        rst_n = 1'b1;
        measure(n, mh);
        check(n == 325, "R9 first pulse edge", n, 325);
        @(negedge clk);
        check(!div_out, "R2 pulse one cycle", div_out, 0);
    endtask

    task automatic t_midchange();
        int n, mh;
        setup(3, 20, 1'b0);
        measure(n, mh);
        measure(n, mh);
        repeat (20) @(negedge clk);
        setup(2, 4, 1'b1);
        measure(n, mh);
        check(n == 643 - 20, "R6 current period unchanged", n + 20, 643);
        measure(n, mh);
        check(n == 258, "R6 new settings next period", n, 258);
    endtask

    task automatic t_fault();
        int n, mh, bad;
        setup(10, 5, 1'b0);          // B < A
        measure(n, mh);
        @(negedge clk);
        check(cfg_fault == 1'b1, "R7 B<A flagged", cfg_fault, 1);
        bad = 0;
        setup(0, 0, 1'b0);           // B = 0
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            if (div_out || modulus_hi || !cfg_fault) bad++;
        end
        check(bad == 0, "R8 quiet during fault B=0", bad, 0);
        setup(32, 40, 1'b0);         // A >= P for P=32
        repeat (3) @(negedge clk);
        check(cfg_fault == 1'b1, "R7 A>=P flagged", cfg_fault, 1);
        setup(32, 40, 1'b1);         // same A valid for P=64
        measure(n, mh);
        check(n == 40 * 64 + 32, "R8 recovery first pulse", n, 2592);
        check(!cfg_fault, "R7 A=32 valid at P=64", cfg_fault, 0);
    endtask

    initial begin
        t_reset();
        run_case(3, 20, 1'b0, "R1 P32");
        run_case(40, 50, 1'b1, "R1 P64 R3");
        run_case(7, 7, 1'b0, "R4 A=B");
        run_case(0, 9, 1'b0, "R5 A=0");
        run_case(0, 31, 1'b0, "R11 min contiguous");
        run_case(31, 31, 1'b0, "R11 top of band");
        run_case(1, 31, 1'b0, "R11 step");
        t_midchange();
        t_fault();
        run_case(63, 255, 1'b1, "R10 max P64");
        run_case(31, 255, 1'b0, "R10 max P32");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end
endmodule